// File: doc/BRIEF.md
# Cipher Register Interface

This block is a bus-slave register file that puts a block-cipher engine under the control of a processor that issues only ordinary 32-bit loads and stores. A small window of word addresses holds a status word, a key area of eight words (room for a 256-bit key), a data area of four words (one 128-bit block) and a direction word. Software loads the key and the input block, then writes the direction word. That write both selects encryption or decryption and launches the engine. Software then polls the ready flag in the status word.

When the engine reports completion, the result overwrites the data area in place. Software collects the processed block by reading the same four addresses it used to write the input. The cipher datapath itself lives outside this block, behind a one-cycle start pulse and a one-cycle done pulse. The processor bus is a single-cycle valid/ready interface. Every access completes in the cycle it is presented, and read data is returned in that same cycle.

Top module: `cipher_regif`

## Requirements
- R1: After reset, ready (status bit 0) is 1, every key word and data word is zero, the direction word reads 1 (encrypt), and `eng_start` is 0.
- R2: The key area occupies the eight words at byte offsets 0x2004, 0x2008, ... 0x2020. A store to the word at 0x2004+4*i sets bits [32*i+31:32*i] of `eng_key`. Loads from the key area return zero, so the key is write-only.
- R3: The data area occupies the four words at 0x2024, 0x2028, 0x202C and 0x2030. A store to the word at 0x2024+4*i sets bits [32*i+31:32*i] of `eng_data_in`, and a load from that word returns the same bits.
- R4: The direction word sits at 0x2034. On a store, write-data bit 0 selects the direction: 1 means encrypt and 0 means decrypt. The selection drives `eng_encrypt`, and a load returns it in bit 0 with zeros above.
- R5: A store to 0x2034 while ready is 1 raises `eng_start` for exactly the one following cycle. In that same cycle ready reads 0.
- R6: Ready stays 0 until `eng_done` is seen. In the cycle after `eng_done`, ready reads 1 and the data area holds `eng_result`, with word i equal to bits [32*i+31:32*i].
- R7: While ready is 0, stores to the key area, the data area and the direction word are ignored.
- R8: The status word sits at 0x2000 and reads ready in bit 0 with zeros above. Stores to it have no effect.
- R9: Loads from any address outside the mapped words return zero. This includes addresses whose two low bits are not zero, and addresses below 0x2000 or above 0x2034. Stores to such addresses change nothing.
- R10: An `eng_done` pulse that arrives while ready is 1 leaves the data area and ready unchanged.
- R11: `bus_ready` is 1 in every cycle, so every access completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_rdata | output | 32 | Load data, valid in the request cycle |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| eng_key | output | 256 | Key held in the key area |
| eng_data_in | output | 128 | Block held in the data area |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_result | input | 128 | Processed block, valid with eng_done |

## Verification
A corrupted ready flag becomes visible at the status address on the very next load. A missed or doubled launch shows on `eng_start` in the cycle after the direction store. A wrong decode or word index appears the moment the affected word is read back, or at once on `eng_key` and `eng_data_in`, because those ports mirror storage directly. A store that leaks through while the engine is busy would alter the engine-facing buses and the read-back in the cycle after that store. Those are the exact points at which the bench samples.

// File: rtl/cregif_pkg.sv
package cregif_pkg;

    // Which mapped word an address selects.
    typedef enum logic [2:0] {
        RGN_NONE   = 3'd0,
        RGN_STATUS = 3'd1,
        RGN_KEY    = 3'd2,
        RGN_DATA   = 3'd3,
        RGN_DIR    = 3'd4
    } region_e;

    // Control state registered by the top.
    typedef struct packed {
        logic ready;
        logic start;
        logic encrypt;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ready: 1'b1, start: 1'b0, encrypt: 1'b1};

endpackage

// File: rtl/cregif_decode.sv
module cregif_decode
    import cregif_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h2000,
    parameter int                KEY_WORDS  = 8,
    parameter int                DATA_WORDS = 4,
    localparam int               KIDX_W     = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
    localparam int               DIDX_W     = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [KIDX_W-1:0] key_idx,
    output logic [DIDX_W-1:0] data_idx
);
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int KEY_LO  = 1;
    localparam int DATA_LO = KEY_LO + KEY_WORDS;
    localparam int DIR_IX  = DATA_LO + DATA_WORDS;

    logic [ADDR_W:0]   diff;
    logic [WIDX_W-1:0] word;
    logic              below;
    logic              aligned;

    always_comb begin
        diff     = {1'b0, addr} - {1'b0, BASE_ADDR};
        below    = diff[ADDR_W];
        aligned  = (diff[1:0] == 2'b00);
        word     = diff[ADDR_W-1:2];
        region   = RGN_NONE;
        key_idx  = KIDX_W'(word - WIDX_W'(KEY_LO));
        data_idx = DIDX_W'(word - WIDX_W'(DATA_LO));
        if (!below && aligned) begin
            if (word == WIDX_W'(0)) begin
                region = RGN_STATUS;
            end else if (word < WIDX_W'(DATA_LO)) begin
                region = RGN_KEY;
            end else if (word < WIDX_W'(DIR_IX)) begin
                region = RGN_DATA;
            end else if (word == WIDX_W'(DIR_IX)) begin
                region = RGN_DIR;
            end
        end
    end

    // Key index must land inside the key bank whenever the key area is hit.
    always_comb begin
        if (region == RGN_KEY) begin
            assert_key_idx_range_R2: assert (int'(key_idx) < KEY_WORDS);
        end
        if (region == RGN_DATA) begin
            assert_data_idx_range_R3: assert (int'(data_idx) < DATA_WORDS);
        end
    end

endmodule

// File: rtl/cregif_wordbank.sv
module cregif_wordbank #(
    parameter int  WORDS    = 4,
    parameter int  WORD_W   = 32,
    parameter bit  HAS_LOAD = 1'b1,
    localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int FLAT_W   = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [FLAT_W-1:0] load_data,
    output logic [FLAT_W-1:0] words_flat
);
    logic [WORDS-1:0][WORD_W-1:0] words_d;
    logic [WORDS-1:0][WORD_W-1:0] words_q;
    logic                         load_hit;

    generate
        if (HAS_LOAD) begin : g_load
            assign load_hit = load_en;
        end else begin : g_noload
            logic unused_load;
            assign unused_load = load_en ^ (^load_data);
            assign load_hit    = 1'b0;
        end
    endgenerate

    always_comb begin
        words_d = words_q;
        if (load_hit) begin
            words_d = load_data;
        end else if (wr_en) begin
            for (int i = 0; i < WORDS; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    words_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words_flat = words_q;

    // The owner never stores and loads the same bank in one cycle (busy gating).
    assert_no_store_load_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && load_hit));

    // A quiet cycle leaves every word untouched.
    assert_bank_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load_hit) |=> $stable(words_q));

endmodule

// File: rtl/cipher_regif.sv
module cipher_regif
    import cregif_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h2000,
    parameter int                WORD_W     = 32,
    parameter int                KEY_WORDS  = 8,
    parameter int                DATA_WORDS = 4,
    localparam int               KEY_W      = KEY_WORDS * WORD_W,
    localparam int               BLK_W      = DATA_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              eng_start,
    output logic              eng_encrypt,
    output logic [KEY_W-1:0]  eng_key,
    output logic [BLK_W-1:0]  eng_data_in,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result
);
    localparam int KIDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
    localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;

    region_e           region;
    logic [KIDX_W-1:0] key_idx;
    logic [DIDX_W-1:0] data_idx;
    ctrl_t             ctrl_d;
    ctrl_t             ctrl_q;
    logic              store;
    logic              key_we;
    logic              data_we;
    logic              data_load;
    logic [DATA_WORDS-1:0][WORD_W-1:0] data_words;

    cregif_decode #(
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR),
        .KEY_WORDS  (KEY_WORDS),
        .DATA_WORDS (DATA_WORDS)
    ) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .key_idx  (key_idx),
        .data_idx (data_idx)
    );

    // Next-state and strobe computation.
    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.start = 1'b0;
        store        = bus_valid && bus_write;
        key_we       = store && ctrl_q.ready && (region == RGN_KEY);
        data_we      = store && ctrl_q.ready && (region == RGN_DATA);
        data_load    = eng_done && !ctrl_q.ready;
        if (ctrl_q.ready) begin
            if (store && (region == RGN_DIR)) begin
                ctrl_d.encrypt = bus_wdata[0];
                ctrl_d.start   = 1'b1;
                ctrl_d.ready   = 1'b0;
            end
        end else if (eng_done) begin
            ctrl_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    cregif_wordbank #(
        .WORDS    (KEY_WORDS),
        .WORD_W   (WORD_W),
        .HAS_LOAD (1'b0)
    ) u_key_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (key_we),
        .wr_idx     (key_idx),
        .wr_data    (bus_wdata),
        .load_en    (1'b0),
        .load_data  ({KEY_W{1'b0}}),
        .words_flat (eng_key)
    );

    cregif_wordbank #(
        .WORDS    (DATA_WORDS),
        .WORD_W   (WORD_W),
        .HAS_LOAD (1'b1)
    ) u_data_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (data_we),
        .wr_idx     (data_idx),
        .wr_data    (bus_wdata),
        .load_en    (data_load),
        .load_data  (eng_result),
        .words_flat (eng_data_in)
    );

    assign data_words = eng_data_in;

    // Load data mux; the key area is write-only.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (region)
                RGN_STATUS: bus_rdata = {{(WORD_W-1){1'b0}}, ctrl_q.ready};
                RGN_DATA:   bus_rdata = data_words[data_idx];
                RGN_DIR:    bus_rdata = {{(WORD_W-1){1'b0}}, ctrl_q.encrypt};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign bus_ready   = 1'b1;
    assign eng_start   = ctrl_q.start;
    assign eng_encrypt = ctrl_q.encrypt;

    // Launch pulse is a single cycle wide.
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // A launch is only issued from the idle state.
    assert_start_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_start) |-> $past(ctrl_q.ready));

    // Busy persists until the engine reports done.
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ready && !eng_done) |=> !ctrl_q.ready);

    // Done while busy returns to idle in the next cycle.
    assert_done_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ready && eng_done) |=> ctrl_q.ready);

    // Key and direction are frozen while the engine runs.
    assert_key_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ready |=> $stable(eng_key));
    assert_dir_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ready |=> $stable(eng_encrypt));

    // Done while idle leaves the data block alone.
    assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ready && eng_done && !(bus_valid && bus_write)) |=> $stable(eng_data_in));

    // Unmapped loads read as zero.
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && region == RGN_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_cipher_regif.sv
`timescale 1ns/1ps
module tb_cipher_regif;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_ready;
    logic [31:0]  bus_rdata;
    logic         eng_start;
    logic         eng_encrypt;
    logic [255:0] eng_key;
    logic [127:0] eng_data_in;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;

    int  applied = 0;
    int  errors  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cipher_regif dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .eng_start   (eng_start),
        .eng_encrypt (eng_encrypt),
        .eng_key     (eng_key),
        .eng_data_in (eng_data_in),
        .eng_done    (eng_done),
        .eng_result  (eng_result)
    );

    // Vector: [80] 1=load-and-compare 0=store, [79:64] addr, [63:32] wdata, [31:0] expected
    localparam int NV = 18;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 16'h2024, 32'hA0A0_0001, 32'h0},
        {1'b0, 16'h2028, 32'hB1B1_0002, 32'h0},
        {1'b0, 16'h202C, 32'hC2C2_0003, 32'h0},
        {1'b0, 16'h2030, 32'hD3D3_0004, 32'h0},
        {1'b1, 16'h2024, 32'h0,         32'hA0A0_0001},
        {1'b1, 16'h2030, 32'h0,         32'hD3D3_0004},
        {1'b0, 16'h2004, 32'h1234_5678, 32'h0},
        {1'b0, 16'h2020, 32'h9ABC_DEF0, 32'h0},
        {1'b1, 16'h2004, 32'h0,         32'h0},
        {1'b1, 16'h2000, 32'h0,         32'h1},
        {1'b0, 16'h2000, 32'h0,         32'h0},
        {1'b1, 16'h2000, 32'h0,         32'h1},
        {1'b1, 16'h2034, 32'h0,         32'h1},
        {1'b1, 16'h2038, 32'h0,         32'h0},
        {1'b1, 16'h2026, 32'h0,         32'h0},
        {1'b0, 16'h203C, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 16'h2028, 32'h0,         32'hB1B1_0002},
        {1'b1, 16'h1FFC, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic [127:0] r);
        @(negedge clk);
        eng_done = 1'b1; eng_result = r;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        do_load(16'h2000, rd);  chk("R1 ready", rd, 1);
        do_load(16'h2034, rd);  chk("R1 direction", rd, 1);
        chk("R1 key", eng_key, 0);
        chk("R1 data", eng_data_in, 0);
        chk("R1 start", eng_start, 0);

        // Table walk: R2 R3 R4 R8 R9
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) begin
                do_load(VEC[i][79:64], rd);
                chk($sformatf("R2/R3/R4/R8/R9 vec %0d", i), rd, VEC[i][31:0]);
            end else begin
                do_store(VEC[i][79:64], VEC[i][63:32]);
                applied++;
            end
        end

        // R2: key words land at their bit slices
        chk("R2 key word0", eng_key[31:0], 32'h1234_5678);
        chk("R2 key word7", eng_key[255:224], 32'h9ABC_DEF0);
        chk("R2 key others", eng_key[223:32], 0);
        // R3: data block mirror; R9: stray store changed nothing
        chk("R3 data block", eng_data_in,
            {32'hD3D3_0004, 32'hC2C2_0003, 32'hB1B1_0002, 32'hA0A0_0001});

        // R11: accepted in the request cycle
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 16'h2000; #1;
        chk("R11 bus_ready", bus_ready, 1);
        bus_valid = 1'b0;

        // R4/R5: decrypt launch
        do_store(16'h2034, 32'h0);
        chk("R5 start pulse", eng_start, 1);
        chk("R4 direction decrypt", eng_encrypt, 0);
        do_load(16'h2000, rd);  chk("R5 ready cleared", rd, 0);
        chk("R5 start single", eng_start, 0);
        do_load(16'h2034, rd);  chk("R4 dir readback", rd, 0);

        // R7: stores while busy are dropped
        do_store(16'h2024, 32'hFFFF_FFFF);
        do_store(16'h2004, 32'h0);
        do_store(16'h2034, 32'h1);
        chk("R7 no relaunch", eng_start, 0);
        do_load(16'h2024, rd);  chk("R7 data kept", rd, 32'hA0A0_0001);
        chk("R7 key kept", eng_key[31:0], 32'h1234_5678);
        chk("R7 dir kept", eng_encrypt, 0);

        // R6: stays busy until done
        repeat (5) @(negedge clk);
        do_load(16'h2000, rd);  chk("R6 still busy", rd, 0);
        pulse_done(128'h4444_4444_3333_3333_2222_2222_1111_1111);
        do_load(16'h2000, rd);  chk("R6 ready after done", rd, 1);
        do_load(16'h2024, rd);  chk("R6 result word0", rd, 32'h1111_1111);
        do_load(16'h2030, rd);  chk("R6 result word3", rd, 32'h4444_4444);

        // R10: done while idle ignored
        pulse_done(128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF);
        chk("R10 data unchanged", eng_data_in, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
        do_load(16'h2000, rd);  chk("R10 ready unchanged", rd, 1);

        // R4/R5: encrypt launch and completion
        do_store(16'h2034, 32'h1);
        chk("R5 second start", eng_start, 1);
        chk("R4 direction encrypt", eng_encrypt, 1);
        pulse_done(128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);
        do_load(16'h202C, rd);  chk("R6 result word2", rd, 32'h89AB_CDEF);
        do_load(16'h2034, rd);  chk("R4 encrypt readback", rd, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule